// File: doc/BRIEF.md
# Four-Phase Clock-Crossing Word Link

This block carries single data words from a sending clock domain into a receiving clock domain whose clock has no fixed relation to the first. Each transfer uses a fully interlocked request/acknowledge exchange. The sender raises a request line. The receiver answers with an acknowledge line. The request falls, and then the acknowledge falls. Only the two one-bit handshake lines cross between the domains, and each one passes through its own chain of synchronizing flops. The word itself sits in a sender-side register that does not move while the request is pending.

On the sending side, the user offers a word together with a one-cycle start pulse whenever the busy flag is low. On the receiving side, the word appears on an output bus together with a valid flag that lasts one receiver cycle. Each domain has its own synchronous active-high reset. A transfer costs a full round trip through both synchronizers, so the block is intended for occasional control words and not for streaming data.

Top module: `hs4_link`

## Requirements
- R1: While its reset is applied, and in the first sampled cycle after it is released, the sender reports `s_busy` = 0 and the receiver reports `r_valid` = 0.
- R2: A start pulse sampled while `s_busy` is 0 is accepted, and `s_busy` reads 1 in the following sender cycle.
- R3: A start pulse given while `s_busy` is 1 is ignored. No extra word is delivered, and the word of the pending transfer is not altered.
- R4: Every accepted word is delivered exactly once, unchanged and in the order accepted, on `r_data` with `r_valid` high.
- R5: `r_valid` is never high for two receiver cycles in a row.
- R6: `s_busy` returns to 0 only after the receiver has delivered the word and the acknowledge has been withdrawn. A start given in the first cycle that `s_busy` is low is then accepted.
- R7: R4 holds when the receiver clock is faster than the sender clock and when it is slower.
- R8: While `r_valid` is low, `r_data` keeps the last delivered word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| s_clk | input | 1 | Sender domain clock |
| s_rst | input | 1 | Sender synchronous reset, active high |
| s_start | input | 1 | One-cycle request to send `s_data` |
| s_data | input | W | Word offered with the start pulse |
| s_busy | output | 1 | High from an accepted start until the handshake has fully closed |
| r_clk | input | 1 | Receiver domain clock |
| r_rst | input | 1 | Receiver synchronous reset, active high |
| r_data | output | W | Last delivered word |
| r_valid | output | 1 | One-cycle strobe marking a newly delivered word |

## Verification
The bench runs one phase with the receiver clock faster than the sender clock and another phase with it slower. A design that recognises the request level twice in a fast receiver would deliver a duplicate word. A design that closes the exchange too early would lose words or deliver them out of order in a slow receiver. In every transfer the bench pokes start again with corrupted data while busy. A design that accepted that pulse would deliver an unexpected word or a changed one. It also issues the next start in the very first idle cycle, so a busy flag that falls before the acknowledge has dropped shows up as a word count that lags behind.

// File: rtl/hs4_link.sv
module hs4_link #(
  parameter int W    = 16,
  parameter int SYNC = 2
) (
  input  logic         s_clk,
  input  logic         s_rst,
  input  logic         s_start,
  input  logic [W-1:0] s_data,
  output logic         s_busy,
  input  logic         r_clk,
  input  logic         r_rst,
  output logic [W-1:0] r_data,
  output logic         r_valid
);

  localparam int SL = (SYNC < 2) ? 2 : SYNC;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_REL} s_state_t;
  typedef enum logic       {R_IDLE, R_HOLD}       r_state_t;

  s_state_t      s_st;
  r_state_t      r_st;
  logic          req, ack;
  logic [W-1:0]  hold;
  logic [SL-1:0] cmd_sy, ack_sy;

  wire cmd_seen = cmd_sy[SL-1];
  wire ack_seen = ack_sy[SL-1];

  assign s_busy = (s_st != S_IDLE);

  always_ff @(posedge s_clk) begin
    if (s_rst) begin
      s_st   <= S_IDLE;
      req    <= 1'b0;
      hold   <= '0;
      ack_sy <= '0;
    end else begin
      ack_sy <= {ack_sy[SL-2:0], ack};
      case (s_st)
        S_IDLE: if (s_start) begin
          hold <= s_data;
          req  <= 1'b1;
          s_st <= S_REQ;
        end
        S_REQ: if (ack_seen) begin
          req  <= 1'b0;
          s_st <= S_REL;
        end
        S_REL: if (!ack_seen) s_st <= S_IDLE;
        default: s_st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge r_clk) begin
    if (r_rst) begin
      r_st    <= R_IDLE;
      ack     <= 1'b0;
      r_valid <= 1'b0;
      r_data  <= '0;
      cmd_sy  <= '0;
    end else begin
      cmd_sy  <= {cmd_sy[SL-2:0], req};
      r_valid <= 1'b0;
      case (r_st)
        R_IDLE: if (cmd_seen) begin
          r_data  <= hold;
          r_valid <= 1'b1;
          ack     <= 1'b1;
          r_st    <= R_HOLD;
        end
        R_HOLD: if (!cmd_seen) begin
          ack  <= 1'b0;
          r_st <= R_IDLE;
        end
        default: r_st <= R_IDLE;
      endcase
    end
  end

endmodule

module hs4_link_chk #(
  parameter int W = 16
) (
  input logic         s_clk,
  input logic         s_rst,
  input logic         s_start,
  input logic         s_busy,
  input logic [W-1:0] hold,
  input logic         r_clk,
  input logic         r_rst,
  input logic         r_valid,
  input logic [W-1:0] r_data
);

  p_busy_rise_r2: assert property (@(posedge s_clk) disable iff (s_rst)
    (!s_busy && s_start) |=> s_busy);

  p_ignore_start_r3: assert property (@(posedge s_clk) disable iff (s_rst)
    (s_busy && s_start) |=> $stable(hold));

  p_hold_stable_r4: assert property (@(posedge s_clk) disable iff (s_rst)
    (s_busy && $past(s_busy)) |-> $stable(hold));

  p_valid_pulse_r5: assert property (@(posedge r_clk) disable iff (r_rst)
    r_valid |=> !r_valid);

  p_data_kept_r8: assert property (@(posedge r_clk) disable iff (r_rst)
    !r_valid |-> $stable(r_data));

endmodule

bind hs4_link hs4_link_chk #(.W(W)) u_chk (
  .s_clk(s_clk), .s_rst(s_rst), .s_start(s_start), .s_busy(s_busy), .hold(hold),
  .r_clk(r_clk), .r_rst(r_rst), .r_valid(r_valid), .r_data(r_data)
);

// File: tb/hs4_link_bench.sv
module hs4_link_bench;
  localparam int W          = 16;
  localparam int CLK_PERIOD = 10;
  localparam int NWORDS     = 40;

  logic s_clk = 0, r_clk = 0;
  logic s_rst = 1, r_rst = 1;
  logic s_start = 0;
  logic [W-1:0] s_data = '0;
  logic s_busy, r_valid;
  logic [W-1:0] r_data;

  int r_half = 3;
  int checks = 0, fails = 0;
  int sent = 0, got = 0;
  bit done = 0;
  logic [W-1:0] expq[$];
  logic [W-1:0] last_word = '0;
  bit prev_valid = 0;

  always #(CLK_PERIOD/2) s_clk = ~s_clk;
  always #(r_half) r_clk = ~r_clk;

  hs4_link #(.W(W)) u_hs4_link (
    .s_clk(s_clk), .s_rst(s_rst), .s_start(s_start), .s_data(s_data), .s_busy(s_busy),
    .r_clk(r_clk), .r_rst(r_rst), .r_data(r_data), .r_valid(r_valid)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge r_clk) begin
    if (!r_rst) begin
      check(!(prev_valid && r_valid), "R5", r_valid, 0);
      if (r_valid) begin
        got++;
        if (expq.size() == 0) check(0, "R3 extra word", r_data, 0);
        else begin
          logic [W-1:0] e;
          e = expq.pop_front();
          check(r_data == e, "R4/R7 word", r_data, e);
        end
        last_word = r_data;
      end else begin
        check(r_data == last_word, "R8", r_data, last_word);
      end
      prev_valid = r_valid;
    end
  end

  task automatic send(input logic [W-1:0] w);
    while (s_busy) @(negedge s_clk);
    s_start = 1; s_data = w;
    expq.push_back(w); sent++;
    @(negedge s_clk);
    s_start = 0;
    check(s_busy == 1, "R2", s_busy, 1);
    s_start = 1; s_data = ~w;
    @(negedge s_clk);
    s_start = 0; s_data = '0;
    while (s_busy) @(negedge s_clk);
    check(got == sent, "R6 delivered before idle", got, sent);
  endtask

  initial begin
    repeat (4) @(negedge s_clk);
    check(s_busy == 0, "R1 busy in reset", s_busy, 0);
    check(r_valid == 0, "R1 valid in reset", r_valid, 0);
    s_rst = 0;
    @(negedge r_clk); r_rst = 0;
    @(negedge s_clk);
    check(s_busy == 0, "R1 busy after reset", s_busy, 0);
    check(r_valid == 0, "R1 valid after reset", r_valid, 0);

    for (int i = 0; i < NWORDS; i++) send(W'(i * 16'h1357 + 16'h00a5));
    repeat (20) @(negedge s_clk);
    check(got == sent, "R7 fast receiver count", got, sent);

    r_half = 17;
    repeat (10) @(negedge s_clk);
    for (int i = 0; i < NWORDS; i++) send(W'(16'hffff - i * 16'h0421));
    repeat (200) @(negedge s_clk);
    check(got == sent, "R7 slow receiver count", got, sent);
    check(expq.size() == 0, "R4 queue drained", expq.size(), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule